// File: doc/BRIEF.md
# Serial Control Word Receiver with Strobe-Width Speed-Up Timer

This block takes control words from a three-wire serial master: a bit clock, a data line and a latch strobe. Bits are taken on each rising edge of the bit clock, most significant bit first. When the strobe rises, the block checks the last four bits received and the number of bits received since the previous strobe edge. If they name a known register and the count is correct, that parallel register is written. Four registers are held: an A word, which may arrive in a standard 24-bit form or an extended 32-bit form, plus B, C and D words of 24 bits each.

The strobe also controls timing. After a strobe rise that loads an A word, a speed-up output stays high for as long as the strobe stays high. A separate saturating counter reports the length of every strobe-high interval in system clock cycles. A reserved all-ones identifier marks a filler word. The master clocks it in while the strobe is high so that the strobe can be held high longer. The filler word writes no register.

All three serial inputs pass through a parameterised synchroniser. They are treated as slow signals relative to the system clock.

Top module: `synth_ctrl_rx`

## Requirements
- R1: After reset, all four word registers, `speedup` and `latch_width` read zero.
- R2: Bits are captured on rising edges of `ser_clk`. The first bit received becomes the most significant bit of the word. In a 24-bit word, bits [23:4] are the payload and bits [3:0] are the identifier.
- R3: At a strobe rise that follows exactly 24 bits, identifier 4'b0001 writes the payload to `word_b`, 4'b1001 writes it to `word_c` and 4'b0101 writes it to `word_d`.
- R4: A 24-bit word with identifier 4'b0000 writes its 20-bit payload to `word_a[19:0]` and leaves `word_a[27:20]` unchanged.
- R5: With `LONG_A_EN`=1, a 32-bit word with identifier 4'b0000 writes bits [31:4] to all 28 bits of `word_a`.
- R6: An unknown identifier, a bit count other than 24 or 32, or a 32-bit word whose identifier is not 4'b0000 changes no register.
- R7: A filler word with identifier 4'b1111 changes no register and does not start speed-up.
- R8: `speedup` rises only at a strobe rise that loads an A word. It stays high for exactly as many cycles as the strobe is high, and it falls with the strobe.
- R9: `latch_width` equals the number of cycles the last strobe pulse was high, saturates at 2^WIDTH_W-1 (255 by default), and holds its value while the strobe is low.
- R10: Each strobe edge restarts the bit count. Bits clocked while the strobe is high do not carry into the next word.
- R11: A bit-clock rise in the same cycle as a strobe edge belongs to the next word. It is neither counted nor decoded with the word that the edge closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock |
| ser_data | input | 1 | Serial data, MSB first |
| ser_latch | input | 1 | Word strobe; its high time sets the speed-up length |
| word_a | output | 28 | A register (low 20 bits standard, upper 8 from the long form) |
| word_b | output | 20 | B register payload |
| word_c | output | 20 | C register payload |
| word_d | output | 20 | D register payload |
| speedup | output | 1 | Speed-up mode active |
| latch_width | output | 8 | Measured strobe-high width, saturating |

## Verification
A bit-clock rise and a strobe edge can be seen in the same synchronised cycle. The word closed by that edge and the count opened by it then meet in one register update. The bench provokes this directly: it raises the bit clock at the same instant it raises the strobe after a complete 24-bit word, and again at the same instant it drops the strobe while sending the first bit of the next word. Each case is judged by whether the closed word still loads from exactly 24 bits and whether the next word loads after only 23 further bits.

// File: rtl/ctrl_rx_pkg.sv
package ctrl_rx_pkg;
   localparam int ID_W = 4;
   localparam logic [ID_W-1:0] ID_A     = 4'b0000;
   localparam logic [ID_W-1:0] ID_B     = 4'b0001;
   localparam logic [ID_W-1:0] ID_C     = 4'b1001;
   localparam logic [ID_W-1:0] ID_D     = 4'b0101;
   localparam logic [ID_W-1:0] ID_FILL  = 4'b1111;

   typedef enum logic [2:0] {
      TGT_NONE,
      TGT_A_STD,
      TGT_A_LONG,
      TGT_B,
      TGT_C,
      TGT_D
   } tgt_e;
endpackage

// File: rtl/ctrl_rx_sync.sv
module ctrl_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk_i,
   input  logic sdat_i,
   input  logic lat_i,
   output logic bit_stb,
   output logic bit_val,
   output logic lat_s,
   output logic lat_d,
   output logic lat_rise,
   output logic lat_fall
);
   logic [2:0] last_q;
   logic       sclk_p;

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("ctrl_rx_sync: STAGES must be at least 1");
      end
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         logic [2:0] q;
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) q <= '0;
               else        q <= {sclk_i, sdat_i, lat_i};
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) q <= '0;
               else        q <= g_stage[g-1].q;
            end
         end
      end
   endgenerate

   assign last_q = g_stage[STAGES-1].q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_p <= 1'b0;
         lat_d  <= 1'b0;
      end else begin
         sclk_p <= last_q[2];
         lat_d  <= last_q[0];
      end
   end

   assign bit_stb  = last_q[2] & ~sclk_p;
   assign bit_val  = last_q[1];
   assign lat_s    = last_q[0];
   assign lat_rise = last_q[0] & ~lat_d;
   assign lat_fall = ~last_q[0] & lat_d;
endmodule

// File: rtl/ctrl_rx_shifter.sv
module ctrl_rx_shifter #(
   parameter int SH_W    = 32,
   parameter int MAX_CNT = 33,
   parameter int CNT_W   = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_stb,
   input  logic             bit_val,
   input  logic             restart,
   output logic [SH_W-1:0]  shreg,
   output logic [CNT_W-1:0] bcnt
);
   localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(MAX_CNT);

   generate
      if ((1 << CNT_W) <= MAX_CNT) begin : g_bad_cnt
         $error("ctrl_rx_shifter: CNT_W too narrow for MAX_CNT");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '0;
      end else if (bit_stb) begin
         shreg <= {shreg[SH_W-2:0], bit_val};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bcnt <= '0;
      end else if (restart) begin
         bcnt <= bit_stb ? CNT_W'(1) : '0;
      end else if (bit_stb && bcnt != CNT_TOP) begin
         bcnt <= bcnt + CNT_W'(1);
      end
   end
endmodule

// File: rtl/ctrl_rx_decode.sv
module ctrl_rx_decode
   import ctrl_rx_pkg::*;
#(
   parameter int STD_BITS  = 24,
   parameter int LONG_BITS = 32,
   parameter bit LONG_A_EN = 1'b1,
   parameter int CNT_W     = 6
) (
   input  logic [ID_W-1:0]  id_bits,
   input  logic [CNT_W-1:0] bcnt,
   output tgt_e             tgt
);
   localparam logic [CNT_W-1:0] N_STD  = CNT_W'(STD_BITS);
   localparam logic [CNT_W-1:0] N_LONG = CNT_W'(LONG_BITS);

   logic long_ok;

   generate
      if (LONG_A_EN) begin : g_long_on
         assign long_ok = (bcnt == N_LONG) && (id_bits == ID_A);
      end else begin : g_long_off
         assign long_ok = 1'b0;
      end
   endgenerate

   always_comb begin
      tgt = TGT_NONE;
      if (long_ok) begin
         tgt = TGT_A_LONG;
      end else if (bcnt == N_STD) begin
         unique case (id_bits)
            ID_A:    tgt = TGT_A_STD;
            ID_B:    tgt = TGT_B;
            ID_C:    tgt = TGT_C;
            ID_D:    tgt = TGT_D;
            default: tgt = TGT_NONE;
         endcase
      end
   end
endmodule

// File: rtl/ctrl_rx_latch_timer.sv
module ctrl_rx_latch_timer #(
   parameter int WIDTH_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               lat_s,
   input  logic               lat_rise,
   input  logic               lat_fall,
   input  logic               a_loaded,
   output logic               speedup,
   output logic [WIDTH_W-1:0] width
);
   localparam logic [WIDTH_W-1:0] W_MAX = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         speedup <= 1'b0;
      end else if (lat_rise) begin
         speedup <= a_loaded;
      end else if (lat_fall) begin
         speedup <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         width <= '0;
      end else if (lat_rise) begin
         width <= WIDTH_W'(1);
      end else if (lat_s && width != W_MAX) begin
         width <= width + WIDTH_W'(1);
      end
   end
endmodule

// File: rtl/synth_ctrl_rx.sv
module synth_ctrl_rx
   import ctrl_rx_pkg::*;
#(
   parameter int STD_BITS    = 24,
   parameter int LONG_BITS   = 32,
   parameter bit LONG_A_EN   = 1'b1,
   parameter int SYNC_STAGES = 2,
   parameter int WIDTH_W     = 8,
   localparam int STD_PAY    = STD_BITS - ID_W,
   localparam int A_W        = LONG_A_EN ? (LONG_BITS - ID_W) : STD_PAY
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ser_clk,
   input  logic               ser_data,
   input  logic               ser_latch,
   output logic [A_W-1:0]     word_a,
   output logic [STD_PAY-1:0] word_b,
   output logic [STD_PAY-1:0] word_c,
   output logic [STD_PAY-1:0] word_d,
   output logic               speedup,
   output logic [WIDTH_W-1:0] latch_width
);
   localparam int SH_W    = LONG_A_EN ? LONG_BITS : STD_BITS;
   localparam int MAX_CNT = LONG_BITS + 1;
   localparam int CNT_W   = $clog2(MAX_CNT + 1);

   generate
      if (STD_BITS <= ID_W) begin : g_bad_std
         $error("synth_ctrl_rx: STD_BITS must exceed the identifier width");
      end
      if (LONG_BITS <= STD_BITS) begin : g_bad_long
         $error("synth_ctrl_rx: LONG_BITS must exceed STD_BITS");
      end
      if (WIDTH_W < 2) begin : g_bad_width
         $error("synth_ctrl_rx: WIDTH_W must be at least 2");
      end
   endgenerate

   logic             bit_stb, bit_val;
   logic             lat_s, lat_d, lat_rise, lat_fall;
   logic [SH_W-1:0]  shreg;
   logic [CNT_W-1:0] bcnt;
   tgt_e             tgt;
   logic             a_loaded;

   ctrl_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .sclk_i   (ser_clk),
      .sdat_i   (ser_data),
      .lat_i    (ser_latch),
      .bit_stb  (bit_stb),
      .bit_val  (bit_val),
      .lat_s    (lat_s),
      .lat_d    (lat_d),
      .lat_rise (lat_rise),
      .lat_fall (lat_fall)
   );

   ctrl_rx_shifter #(.SH_W(SH_W), .MAX_CNT(MAX_CNT), .CNT_W(CNT_W)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .bit_stb (bit_stb),
      .bit_val (bit_val),
      .restart (lat_rise | lat_fall),
      .shreg   (shreg),
      .bcnt    (bcnt)
   );

   ctrl_rx_decode #(
      .STD_BITS  (STD_BITS),
      .LONG_BITS (LONG_BITS),
      .LONG_A_EN (LONG_A_EN),
      .CNT_W     (CNT_W)
   ) u_dec (
      .id_bits (shreg[ID_W-1:0]),
      .bcnt    (bcnt),
      .tgt     (tgt)
   );

   assign a_loaded = lat_rise && (tgt == TGT_A_STD || tgt == TGT_A_LONG);

   // register bank: written only on a strobe rise
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_b <= '0;
         word_c <= '0;
         word_d <= '0;
      end else if (lat_rise) begin
         if (tgt == TGT_B) word_b <= shreg[STD_BITS-1:ID_W];
         if (tgt == TGT_C) word_c <= shreg[STD_BITS-1:ID_W];
         if (tgt == TGT_D) word_d <= shreg[STD_BITS-1:ID_W];
      end
   end

   generate
      if (LONG_A_EN) begin : g_a_long
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               word_a <= '0;
            end else if (lat_rise) begin
               if (tgt == TGT_A_LONG)
                  word_a <= shreg[LONG_BITS-1:ID_W];
               else if (tgt == TGT_A_STD)
                  word_a[STD_PAY-1:0] <= shreg[STD_BITS-1:ID_W];
            end
         end
      end else begin : g_a_short
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               word_a <= '0;
            end else if (lat_rise && tgt == TGT_A_STD) begin
               word_a <= shreg[STD_BITS-1:ID_W];
            end
         end
      end
   endgenerate

   ctrl_rx_latch_timer #(.WIDTH_W(WIDTH_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .lat_s    (lat_s),
      .lat_rise (lat_rise),
      .lat_fall (lat_fall),
      .a_loaded (a_loaded),
      .speedup  (speedup),
      .width    (latch_width)
   );
endmodule

// File: rtl/ctrl_rx_chk.sv
module ctrl_rx_chk #(
   parameter int A_W     = 28,
   parameter int PAY_W   = 20,
   parameter int WIDTH_W = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               lat_s,
   input logic               lat_d,
   input logic               speedup,
   input logic [WIDTH_W-1:0] latch_width,
   input logic [A_W-1:0]     word_a,
   input logic [PAY_W-1:0]   word_b,
   input logic [PAY_W-1:0]   word_c,
   input logic [PAY_W-1:0]   word_d
);
   // R8
   speedup_needs_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      speedup |-> lat_d);

   // R8
   speedup_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(speedup) |-> $past(lat_s && !lat_d));

   // R9
   width_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lat_s |=> $stable(latch_width));

   // R9
   width_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (latch_width >= $past(latch_width)) || (latch_width == WIDTH_W'(1)));

   // R6
   regs_only_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(lat_s && !lat_d) |=> ($stable(word_a) && $stable(word_b)
                              && $stable(word_c) && $stable(word_d)));
endmodule

bind synth_ctrl_rx ctrl_rx_chk #(.A_W(A_W), .PAY_W(STD_PAY), .WIDTH_W(WIDTH_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .lat_s       (lat_s),
   .lat_d       (lat_d),
   .speedup     (speedup),
   .latch_width (latch_width),
   .word_a      (word_a),
   .word_b      (word_b),
   .word_c      (word_c),
   .word_d      (word_d)
);

// File: tb/test_synth_ctrl_rx.sv
`timescale 1ns/1ps
module test_synth_ctrl_rx;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ser_clk = 1'b0, ser_data = 1'b0, ser_latch = 1'b0;
   logic [27:0] word_a;
   logic [19:0] word_b, word_c, word_d;
   logic        speedup;
   logic [7:0]  latch_width;

   int compared = 0;
   int mismatched = 0;
   bit done = 1'b0;

   logic [27:0] ea;
   logic [19:0] eb, ec, ed;

   always #5 clk = ~clk;

   synth_ctrl_rx i_synth_ctrl_rx (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
      .ser_latch(ser_latch), .word_a(word_a), .word_b(word_b), .word_c(word_c),
      .word_d(word_d), .speedup(speedup), .latch_width(latch_width)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // reference model; returns 1 when an A word is loaded
   function automatic bit model(input logic [63:0] w, input int n);
      logic [3:0] id = w[3:0];
      if (n == 32 && id == 4'b0000) begin
         ea = w[31:4];
         return 1'b1;
      end
      if (n != 24) return 1'b0;
      case (id)
         4'b0000: begin ea[19:0] = w[23:4]; return 1'b1; end
         4'b0001: eb = w[23:4];
         4'b1001: ec = w[23:4];
         4'b0101: ed = w[23:4];
         default: ;
      endcase
      return 1'b0;
   endfunction

   task automatic send_from(input logic [63:0] w, input int top);
      for (int i = top; i >= 0; i--) begin
         ser_data = w[i];
         ser_clk  = 1'b0;
         repeat (2) @(negedge clk);
         ser_clk  = 1'b1;
         repeat (2) @(negedge clk);
      end
   endtask

   task automatic pulse(input int h, output int su);
      su = 0;
      ser_latch = 1'b1;
      repeat (h) begin
         @(negedge clk);
         if (speedup) su++;
      end
      ser_latch = 1'b0;
      repeat (8) begin
         @(negedge clk);
         if (speedup) su++;
      end
   endtask

   task automatic check_regs(input string req);
      chk({req, " word_a"}, 64'(word_a), 64'(ea));
      chk({req, " word_b"}, 64'(word_b), 64'(eb));
      chk({req, " word_c"}, 64'(word_c), 64'(ec));
      chk({req, " word_d"}, 64'(word_d), 64'(ed));
   endtask

   task automatic xfer(input logic [63:0] w, input int n, input int h, input string req);
      int su;
      bit isa;
      send_from(w, n - 1);
      pulse(h, su);
      isa = model(w, n);
      check_regs(req);
      chk({req, " speedup cycles R8"}, 64'(su), isa ? 64'(h) : 64'd0);
      chk({req, " width R9"}, 64'(latch_width), 64'((h > 255) ? 255 : h));
   endtask

   initial begin
      #(10ns * 150000);
      if (!done) begin
         mismatched++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      int su;
      int dummy_seed;
      dummy_seed = $urandom(20240611);
      ea = '0; eb = '0; ec = '0; ed = '0;
      repeat (4) @(negedge clk);
      // R1 reset state
      check_regs("R1");
      chk("R1 speedup", 64'(speedup), 64'd0);
      chk("R1 width", 64'(latch_width), 64'd0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R2 MSB first: distinctive B payload
      xfer(64'h80001_1, 24, 4, "R2 msb-first B");
      // R3 each target
      xfer(64'hA5A5A_9, 24, 5, "R3 C load");
      xfer(64'h3C3C3_5, 24, 6, "R3 D load");
      // R5 long A, then R4 standard A preserves upper bits
      xfer(64'hDEADBEE_0, 32, 7, "R5 long A");
      xfer(64'h12345_0, 24, 9, "R4 std A");
      // R6 wrong length, unknown id, long non-A
      xfer(64'h55555_1, 23, 3, "R6 short word");
      xfer(64'h66666_1, 25, 3, "R6 long word");
      xfer(64'h77777_7, 24, 3, "R6 unknown id");
      xfer(64'hCAFEF00_1, 32, 3, "R6 long B");
      // R7 filler word sent with strobe low
      xfer(64'hFFFFFF, 24, 6, "R7 filler");

      // R8 R10: A load, strobe stretched by a filler word clocked while high
      send_from(64'hABCDE_0, 23);
      void'(model(64'hABCDE_0, 24));
      su = 0;
      ser_latch = 1'b1;
      for (int i = 23; i >= 0; i--) begin
         ser_data = 1'b1;
         ser_clk = 1'b0;
         repeat (2) begin @(negedge clk); if (speedup) su++; end
         ser_clk = 1'b1;
         repeat (2) begin @(negedge clk); if (speedup) su++; end
      end
      ser_latch = 1'b0;
      repeat (8) begin @(negedge clk); if (speedup) su++; end
      check_regs("R7 filler while high");
      chk("R8 stretched speedup", 64'(su), 64'd96);
      chk("R9 stretched width", 64'(latch_width), 64'd96);
      xfer(64'h0F0F0_1, 24, 4, "R10 count restart");

      // R9 saturation, with and without speed-up
      xfer(64'h11111_5, 24, 300, "R9 saturate");
      xfer(64'h22222_0, 24, 300, "R8 long speedup");

      // R11 bit-clock rise coincident with strobe rise
      send_from(64'h13579_9, 23);
      @(negedge clk);
      ser_data = 1'b0;
      ser_clk  = 1'b0;
      repeat (2) @(negedge clk);
      ser_clk = 1'b1;
      pulse(5, su);
      void'(model(64'h13579_9, 24));
      check_regs("R11 coincident rise");
      chk("R11 no speedup", 64'(su), 64'd0);

      // R11 bit-clock rise coincident with strobe fall
      ser_clk = 1'b0;
      repeat (2) @(negedge clk);
      ser_latch = 1'b1;
      repeat (5) @(negedge clk);
      ser_data = 1'b1;            // bit 23 of 0x86420_5 is 1
      ser_clk = 1'b1;
      ser_latch = 1'b0;
      repeat (2) @(negedge clk);
      send_from(64'h86420_5, 22);
      pulse(4, su);
      void'(model(64'h86420_5, 24));
      check_regs("R11 coincident fall");

      // constrained random traffic
      for (int t = 0; t < 40; t++) begin
         logic [63:0] w;
         int n, h, pick;
         w = {$urandom, $urandom};
         pick = $urandom_range(0, 9);
         case (pick)
            0: w[3:0] = 4'b0000;
            1: w[3:0] = 4'b0001;
            2: w[3:0] = 4'b1001;
            3: w[3:0] = 4'b0101;
            4: w[3:0] = 4'b1111;
            5: w[3:0] = 4'b0000;
            default: ;
         endcase
         pick = $urandom_range(0, 9);
         n = (pick < 6) ? 24 : (pick < 8) ? 32 : $urandom_range(18, 34);
         h = $urandom_range(1, 20);
         xfer(w, n, h, "R3 R6 random");
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule